// File: doc/BRIEF.md
# Vectored Interrupt Priority Resolver

This block keeps the interrupt state of one processor. The state covers 256 numbered vectors. Each vector has three bits: a request bit, an in-service bit and a trigger-mode bit. The block also keeps a task-priority value and a small control word, which holds a global enable, a spurious vector and a directed-EOI flag.

Request sources post vectors through a set port. The processor side works through three strobes:

- An acknowledge strobe takes the best deliverable request and returns it.
- An end-of-interrupt strobe retires the highest vector in service.
- Write strobes update the task priority and the control word.

The block computes the processor priority from the task priority and from the priority class of the highest vector in service. A class is the upper four bits of a vector. Requests are masked by class, not by single vector. When a retired vector was level-triggered, the block sends a one-cycle broadcast so that the source can re-sample its line.

Top module: `vec_prio_resolver`

## Requirements
- R1: Among pending requests, the highest-numbered vector is always the one selected.
- R2: The processor priority `ppr` depends on two classes: the task-priority class (`tpr[7:4]`) and the class of the highest in-service vector, where an empty in-service set counts as class 0. When the task-priority class is greater than or equal to the in-service class, `ppr` equals the full task-priority value. Otherwise `ppr` equals the in-service class shifted left by 4.
- R3: A request is masked when two conditions both hold: `ppr` is nonzero, and the request's class is less than or equal to `ppr[7:4]`. A request whose class equals the priority class is masked.
- R4: An acknowledge of an unmasked request returns ack_kind 1 with that vector on `ack_vec`. It also moves the vector from the request set to the in-service set. When the best request is masked, the acknowledge returns ack_kind 2 with the spurious vector and leaves the state unchanged.
- R5: While the enable bit is clear, `irq_pending` stays low and an acknowledge returns ack_kind 0 (none).
- R6: Each set request records its trigger mode in the trigger bit of its vector: 1 for level, 0 for edge. The most recent request for a vector decides that bit.
- R7: End-of-interrupt clears the highest in-service vector. If that vector is level-triggered, the block pulses `eoi_bcast` for one cycle and shows the vector on `eoi_bcast_vec`.
- R8: When the directed-EOI flag (bit 12 of the control word write) is set, no broadcast is sent.
- R9: A write on the control-register path stores the 4-bit value into `tpr[7:4]` and zero into `tpr[3:0]`.
- R10: A control word write keeps only three fields: bits 7:0 as the spurious vector, bit 8 as the enable, and bit 12 as the directed-EOI flag. All other bits are dropped.
- R11: An end-of-interrupt with nothing in service changes nothing and sends no broadcast. An acknowledge with no pending request returns ack_kind 0.
- R12: After reset all vector sets are empty, the task priority is 0 and the control word is 0, so the block is disabled. All outputs are idle.
- R13: `irq_pending` and `ppr` reflect the state in the cycle after the edge that changed it. `ack_*` and `eoi_bcast*` are registered and valid for one cycle after their strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_req | input | 1 | Post a request for `set_vec` |
| set_vec | input | 8 | Vector to request |
| set_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| ack | input | 1 | Acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Full task-priority write |
| tpr_wdata | input | 8 | Task-priority value |
| cr_wr | input | 1 | Control-register-path priority write (lower priority than `tpr_wr`) |
| cr_wdata | input | 4 | Priority class for `tpr[7:4]` |
| svr_wr | input | 1 | Control word write |
| svr_wdata | input | 16 | Control word value |
| irq_pending | output | 1 | An unmasked request exists and the block is enabled |
| ack_kind | output | 2 | 0 none, 1 vector, 2 spurious |
| ack_vec | output | 8 | Vector returned by the last acknowledge |
| ppr | output | 8 | Processor priority |
| eoi_bcast | output | 1 | One-cycle broadcast for a retired level vector |
| eoi_bcast_vec | output | 8 | Vector carried by the broadcast |

## Verification
A single scripted sequence works through the state machine. It drives requests in several vector orders: a lower vector queued behind a higher one, nested acknowledges, and the same vector re-requested with the opposite trigger mode.

Each step is chosen to separate two outcomes:

- Task-priority values are set above, equal to and below the request class. This separates "deliver" from "spurious".
- Full task-priority writes are compared against control-path writes.
- End-of-interrupt is applied to edge vectors, to level vectors and to an empty in-service set. This separates the cases with and without a broadcast.
- The enable bit and the directed-EOI flag are toggled. This shows which control bits are kept.

// File: rtl/vpr_pkg.sv
package vpr_pkg;

    localparam int VPR_VEC_W    = 8;
    localparam int VPR_CLS_LSB  = 4;
    localparam int VPR_SVR_IN_W = 16;
    localparam int VPR_EN_BIT   = 8;
    localparam int VPR_DIR_BIT  = 12;

    typedef enum logic [1:0] {
        ACK_NONE = 2'd0,
        ACK_VEC  = 2'd1,
        ACK_SPUR = 2'd2
    } ack_kind_e;

    // Retained control word: only three fields survive a write.
    typedef struct packed {
        logic                 dir_eoi;
        logic                 enable;
        logic [VPR_VEC_W-1:0] spur;
    } svr_t;

    // Result of a highest-set-bit search.
    typedef struct packed {
        logic                 hit;
        logic [VPR_VEC_W-1:0] idx;
    } top_t;

    function automatic svr_t svr_decode(input logic [VPR_SVR_IN_W-1:0] w);
        svr_t s;
        s.spur    = w[VPR_VEC_W-1:0];
        s.enable  = w[VPR_EN_BIT];
        s.dir_eoi = w[VPR_DIR_BIT];
        return s;
    endfunction

endpackage

// File: rtl/vpr_msb_find.sv
module vpr_msb_find #(
    parameter int N      = 256,
    parameter int WORD_W = 32
) (
    input  logic [N-1:0]         vec_i,
    output logic                 hit_o,
    output logic [$clog2(N)-1:0] idx_o
);
    localparam int NW = N / WORD_W;
    localparam int BW = $clog2(WORD_W);
    localparam int WW = (NW > 1) ? $clog2(NW) : 1;
    localparam int IW = $clog2(N);

    logic [NW-1:0]         word_hit;
    logic [NW-1:0][BW-1:0] word_pos;

    // First level: highest set bit inside each word.
    for (genvar g = 0; g < NW; g++) begin : g_word
        logic [WORD_W-1:0] slice;
        logic [BW-1:0]     pos;
        assign slice = vec_i[g*WORD_W +: WORD_W];
        always_comb begin
            pos = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (slice[b]) pos = BW'(b);
            end
        end
        assign word_hit[g] = |slice;
        assign word_pos[g] = pos;
    end

    // Second level: highest non-empty word wins.
    always_comb begin
        hit_o = |word_hit;
        idx_o = '0;
        for (int w = 0; w < NW; w++) begin
            if (word_hit[w]) idx_o = IW'({WW'(w), word_pos[w]});
        end
    end
endmodule

// File: rtl/vpr_ppr_unit.sv
module vpr_ppr_unit
    import vpr_pkg::*;
#(
    parameter int VEC_W   = VPR_VEC_W,
    parameter int CLS_LSB = VPR_CLS_LSB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VEC_W-1:0] tpr_i,
    input  top_t             isr_top_i,
    input  top_t             irr_top_i,
    input  logic             enable_i,
    output logic [VEC_W-1:0] ppr_o,
    output logic             masked_o,
    output logic             deliver_o
);
    localparam int CW = VEC_W - CLS_LSB;

    logic [CW-1:0] tpr_cls, isr_cls, irr_cls, ppr_cls;

    always_comb begin
        tpr_cls = tpr_i[VEC_W-1:CLS_LSB];
        isr_cls = isr_top_i.hit ? isr_top_i.idx[VEC_W-1:CLS_LSB] : '0;
        irr_cls = irr_top_i.idx[VEC_W-1:CLS_LSB];
        ppr_o   = (tpr_cls >= isr_cls) ? tpr_i : {isr_cls, {CLS_LSB{1'b0}}};
        ppr_cls = ppr_o[VEC_W-1:CLS_LSB];
        masked_o  = irr_top_i.hit && (ppr_o != '0) && (irr_cls <= ppr_cls);
        deliver_o = enable_i && irr_top_i.hit && !masked_o;
    end

    // R2: priority never drops below the class of the vector in service
    a_r2_ppr_covers_isr: assert property (@(posedge clk) disable iff (rst)
        isr_top_i.hit |-> (ppr_o[VEC_W-1:CLS_LSB] >= isr_top_i.idx[VEC_W-1:CLS_LSB]));

    // R3: a delivered request always sits above the priority class
    a_r3_deliver_above_class: assert property (@(posedge clk) disable iff (rst)
        deliver_o |-> (irr_top_i.idx[VEC_W-1:CLS_LSB] > ppr_o[VEC_W-1:CLS_LSB]) || (ppr_o == '0));
endmodule

// File: rtl/vec_prio_resolver.sv
module vec_prio_resolver
    import vpr_pkg::*;
#(
    parameter int VEC_W   = VPR_VEC_W,
    parameter int CLS_LSB = VPR_CLS_LSB,
    parameter int WORD_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     set_req,
    input  logic [VEC_W-1:0]         set_vec,
    input  logic                     set_level,
    input  logic                     ack,
    input  logic                     eoi,
    input  logic                     tpr_wr,
    input  logic [VEC_W-1:0]         tpr_wdata,
    input  logic                     cr_wr,
    input  logic [VEC_W-CLS_LSB-1:0] cr_wdata,
    input  logic                     svr_wr,
    input  logic [VPR_SVR_IN_W-1:0]  svr_wdata,
    output logic                     irq_pending,
    output logic [1:0]               ack_kind,
    output logic [VEC_W-1:0]         ack_vec,
    output logic [VEC_W-1:0]         ppr,
    output logic                     eoi_bcast,
    output logic [VEC_W-1:0]         eoi_bcast_vec
);
    localparam int NUM_VEC = 1 << VEC_W;

    logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
    logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
    logic [VEC_W-1:0]   tpr_q, tpr_n;
    svr_t               svr_q, svr_n;
    top_t               irr_top, isr_top;
    logic               masked, deliver;
    ack_kind_e          ack_kind_q, ack_kind_n;
    logic [VEC_W-1:0]   ack_vec_q, ack_vec_n;
    logic               bc_q, bc_n;
    logic [VEC_W-1:0]   bc_vec_q, bc_vec_n;

    vpr_msb_find #(.N(NUM_VEC), .WORD_W(WORD_W)) u_irr_find (
        .vec_i(irr_q), .hit_o(irr_top.hit), .idx_o(irr_top.idx)
    );

    vpr_msb_find #(.N(NUM_VEC), .WORD_W(WORD_W)) u_isr_find (
        .vec_i(isr_q), .hit_o(isr_top.hit), .idx_o(isr_top.idx)
    );

    vpr_ppr_unit #(.VEC_W(VEC_W), .CLS_LSB(CLS_LSB)) u_ppr (
        .clk(clk), .rst(rst),
        .tpr_i(tpr_q), .isr_top_i(isr_top), .irr_top_i(irr_top),
        .enable_i(svr_q.enable),
        .ppr_o(ppr), .masked_o(masked), .deliver_o(deliver)
    );

    always_comb begin
        irr_n = irr_q;
        isr_n = isr_q;
        tmr_n = tmr_q;
        tpr_n = tpr_q;
        svr_n = svr_q;
        ack_kind_n = ACK_NONE;
        ack_vec_n  = '0;
        bc_n       = 1'b0;
        bc_vec_n   = '0;

        if (ack && svr_q.enable && irr_top.hit) begin
            if (deliver) begin
                irr_n[irr_top.idx] = 1'b0;
                isr_n[irr_top.idx] = 1'b1;
                ack_kind_n = ACK_VEC;
                ack_vec_n  = irr_top.idx;
            end else begin
                ack_kind_n = ACK_SPUR;
                ack_vec_n  = svr_q.spur;
            end
        end

        if (eoi && isr_top.hit) begin
            isr_n[isr_top.idx] = 1'b0;
            if (tmr_q[isr_top.idx] && !svr_q.dir_eoi) begin
                bc_n     = 1'b1;
                bc_vec_n = isr_top.idx;
            end
        end

        if (set_req) begin
            irr_n[set_vec] = 1'b1;
            tmr_n[set_vec] = set_level;
        end

        if (tpr_wr)     tpr_n = tpr_wdata;
        else if (cr_wr) tpr_n = {cr_wdata, {CLS_LSB{1'b0}}};

        if (svr_wr) svr_n = svr_decode(svr_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q      <= '0;
            isr_q      <= '0;
            tmr_q      <= '0;
            tpr_q      <= '0;
            svr_q      <= '0;
            ack_kind_q <= ACK_NONE;
            ack_vec_q  <= '0;
            bc_q       <= 1'b0;
            bc_vec_q   <= '0;
        end else begin
            irr_q      <= irr_n;
            isr_q      <= isr_n;
            tmr_q      <= tmr_n;
            tpr_q      <= tpr_n;
            svr_q      <= svr_n;
            ack_kind_q <= ack_kind_n;
            ack_vec_q  <= ack_vec_n;
            bc_q       <= bc_n;
            bc_vec_q   <= bc_vec_n;
        end
    end

    assign irq_pending   = deliver;
    assign ack_kind      = ack_kind_q;
    assign ack_vec       = ack_vec_q;
    assign eoi_bcast     = bc_q;
    assign eoi_bcast_vec = bc_vec_q;

    // R5: disabled block never reports a pending request
    a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !svr_q.enable |-> !irq_pending);

    // R6: pending implies some request bit is held
    a_r6_pending_needs_req: assert property (@(posedge clk) disable iff (rst)
        irq_pending |-> (|irr_q));

    // R4: a returned vector is now in service
    a_r4_ack_in_service: assert property (@(posedge clk) disable iff (rst)
        (ack_kind_q == ACK_VEC) |-> isr_q[ack_vec_q]);

    // R2: processor priority is never below the task priority
    a_r2_ppr_floor: assert property (@(posedge clk) disable iff (rst)
        ppr >= tpr_q);

    // R7: a broadcast follows an EOI and its vector has left service
    a_r7_bcast_cause: assert property (@(posedge clk) disable iff (rst)
        eoi_bcast |-> ($past(eoi) && !isr_q[eoi_bcast_vec]));

    // R8: directed-EOI flag suppresses the broadcast
    a_r8_directed_quiet: assert property (@(posedge clk) disable iff (rst)
        eoi_bcast |-> !$past(svr_q.dir_eoi));

    // R11: EOI on an empty in-service set sends nothing
    a_r11_empty_eoi: assert property (@(posedge clk) disable iff (rst)
        (eoi && !(|isr_q)) |=> !eoi_bcast);
endmodule

// File: tb/vec_prio_resolver_tb.sv
module vec_prio_resolver_tb_top;

    localparam int NROWS = 38;

    typedef struct packed {
        logic [2:0]  op;     // 0 set,1 ack,2 eoi,3 tpr,4 cr,5 svr
        logic [15:0] arg;
        logic        lvl;
        logic [1:0]  xkind;
        logic [7:0]  xvec;   // ack vector or broadcast vector
        logic        xbc;
        logic        xpend;
        logic [7:0]  xppr;
        logic [3:0]  req;    // requirement number for messages
    } row_t;

    localparam row_t ROWS [NROWS] = '{
        '{3'd0, 16'h0045, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd5},  // R5 set while off
        '{3'd1, 16'h0000, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd5},  // R5 ack while off
        '{3'd5, 16'hE1FF, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h00, 4'd10}, // R10 enable
        '{3'd0, 16'h0092, 1'b1, 2'd0, 8'h00, 1'b0, 1'b1, 8'h00, 4'd6},  // R6 level
        '{3'd1, 16'h0000, 1'b0, 2'd1, 8'h92, 1'b0, 1'b0, 8'h90, 4'd1},  // R1 R4
        '{3'd0, 16'h00A0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h90, 4'd3},  // R3 above class
        '{3'd1, 16'h0000, 1'b0, 2'd1, 8'hA0, 1'b0, 1'b0, 8'hA0, 4'd1},  // R1 nested
        '{3'd1, 16'h0000, 1'b0, 2'd2, 8'hFF, 1'b0, 1'b0, 8'hA0, 4'd4},  // R4 spurious
        '{3'd2, 16'h0000, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h90, 4'd7},  // R7 edge, no bcast
        '{3'd2, 16'h0000, 1'b0, 2'd0, 8'h92, 1'b1, 1'b1, 8'h00, 4'd7},  // R7 level bcast
        '{3'd3, 16'h0050, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h50, 4'd2},  // R2 full tpr
        '{3'd4, 16'h0003, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h30, 4'd9},  // R9 cr path
        '{3'd3, 16'h004C, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h4C, 4'd3},  // R3 equal class
        '{3'd1, 16'h0000, 1'b0, 2'd2, 8'hFF, 1'b0, 1'b0, 8'h4C, 4'd4},  // R4
        '{3'd3, 16'h0000, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h00, 4'd2},
        '{3'd1, 16'h0000, 1'b0, 2'd1, 8'h45, 1'b0, 1'b0, 8'h40, 4'd2},  // R2 isr class
        '{3'd2, 16'h0000, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd7},
        '{3'd2, 16'h0000, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd11}, // R11 empty eoi
        '{3'd1, 16'h0000, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd11}, // R11 empty ack
        '{3'd0, 16'h0031, 1'b1, 2'd0, 8'h00, 1'b0, 1'b1, 8'h00, 4'd6},
        '{3'd0, 16'h0031, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h00, 4'd6},  // R6 re-request edge
        '{3'd1, 16'h0000, 1'b0, 2'd1, 8'h31, 1'b0, 1'b0, 8'h30, 4'd4},
        '{3'd2, 16'h0000, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd6},  // R6 no bcast
        '{3'd5, 16'h11AB, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd8},  // R8 directed on
        '{3'd0, 16'h0060, 1'b1, 2'd0, 8'h00, 1'b0, 1'b1, 8'h00, 4'd8},
        '{3'd1, 16'h0000, 1'b0, 2'd1, 8'h60, 1'b0, 1'b0, 8'h60, 4'd4},
        '{3'd2, 16'h0000, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd8},  // R8 suppressed
        '{3'd0, 16'h0070, 1'b1, 2'd0, 8'h00, 1'b0, 1'b1, 8'h00, 4'd1},
        '{3'd0, 16'h0020, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h00, 4'd1},
        '{3'd3, 16'h0070, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h70, 4'd3},  // R3
        '{3'd1, 16'h0000, 1'b0, 2'd2, 8'hAB, 1'b0, 1'b0, 8'h70, 4'd10}, // R10 new spurious
        '{3'd5, 16'h02AB, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h70, 4'd10}, // R10 bit9 dropped
        '{3'd1, 16'h0000, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h70, 4'd5},  // R5
        '{3'd5, 16'h01AB, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h70, 4'd10},
        '{3'd3, 16'h0000, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h00, 4'd13}, // R13
        '{3'd1, 16'h0000, 1'b0, 2'd1, 8'h70, 1'b0, 1'b0, 8'h70, 4'd1},
        '{3'd2, 16'h0000, 1'b0, 2'd0, 8'h70, 1'b1, 1'b1, 8'h00, 4'd7},  // R7 again
        '{3'd1, 16'h0000, 1'b0, 2'd1, 8'h20, 1'b0, 1'b0, 8'h20, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        set_req, set_level, ack, eoi, tpr_wr, cr_wr, svr_wr;
    logic [7:0]  set_vec, tpr_wdata;
    logic [3:0]  cr_wdata;
    logic [15:0] svr_wdata;
    logic        irq_pending, eoi_bcast;
    logic [1:0]  ack_kind;
    logic [7:0]  ack_vec, ppr, eoi_bcast_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    vec_prio_resolver dut_i (
        .clk(clk), .rst(rst),
        .set_req(set_req), .set_vec(set_vec), .set_level(set_level),
        .ack(ack), .eoi(eoi),
        .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
        .cr_wr(cr_wr), .cr_wdata(cr_wdata),
        .svr_wr(svr_wr), .svr_wdata(svr_wdata),
        .irq_pending(irq_pending), .ack_kind(ack_kind), .ack_vec(ack_vec),
        .ppr(ppr), .eoi_bcast(eoi_bcast), .eoi_bcast_vec(eoi_bcast_vec)
    );

    task automatic chk(input string what, input int rq, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, got, exp);
        end
    endtask

    task automatic idle_inputs();
        set_req = 0; set_level = 0; set_vec = '0; ack = 0; eoi = 0;
        tpr_wr = 0; tpr_wdata = '0; cr_wr = 0; cr_wdata = '0;
        svr_wr = 0; svr_wdata = '0;
    endtask

    task automatic check_idle(input int rq);
        chk("pending", rq, 16'(irq_pending), 16'h0);
        chk("ppr", rq, 16'(ppr), 16'h0);
        chk("ack_kind", rq, 16'(ack_kind), 16'h0);
        chk("bcast", rq, 16'(eoi_bcast), 16'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle(12); // R12 reset state

        for (int i = 0; i < NROWS; i++) begin
            row_t r;
            r = ROWS[i];
            case (r.op)
                3'd0: begin set_req = 1; set_vec = r.arg[7:0]; set_level = r.lvl; end
                3'd1: ack = 1;
                3'd2: eoi = 1;
                3'd3: begin tpr_wr = 1; tpr_wdata = r.arg[7:0]; end
                3'd4: begin cr_wr = 1; cr_wdata = r.arg[3:0]; end
                default: begin svr_wr = 1; svr_wdata = r.arg; end
            endcase
            @(posedge clk);
            @(negedge clk);
            idle_inputs();
            chk($sformatf("row %0d pending", i), r.req, 16'(irq_pending), 16'(r.xpend));
            chk($sformatf("row %0d ppr", i), r.req, 16'(ppr), 16'(r.xppr));
            chk($sformatf("row %0d ack_kind", i), r.req, 16'(ack_kind),
                (r.op == 3'd1) ? 16'(r.xkind) : 16'h0);
            if (r.op == 3'd1 && r.xkind != 2'd0)
                chk($sformatf("row %0d ack_vec", i), r.req, 16'(ack_vec), 16'(r.xvec));
            chk($sformatf("row %0d bcast", i), r.req, 16'(eoi_bcast), 16'(r.xbc));
            if (r.xbc)
                chk($sformatf("row %0d bcast_vec", i), r.req, 16'(eoi_bcast_vec), 16'(r.xvec));
        end

        // R13: broadcast lasts exactly one cycle
        @(negedge clk);
        chk("bcast one cycle", 13, 16'(eoi_bcast), 16'h0);

        // R12: reset mid-run empties all state
        set_req = 1; set_vec = 8'hC4; set_level = 1;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        check_idle(12);
        svr_wr = 1; svr_wdata = 16'h01FF;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        chk("pending after reset", 12, 16'(irq_pending), 16'h0);
        ack = 1;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        chk("ack after reset", 12, 16'(ack_kind), 16'h0);

        // R9: tpr_wr wins over the control-register path in the same cycle
        tpr_wr = 1; tpr_wdata = 8'h27; cr_wr = 1; cr_wdata = 4'h9;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        chk("tpr priority", 9, 16'(ppr), 16'h0027);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule